// File: doc/BRIEF.md
# Serial Audio Frame Transmitter

This block turns a stream of 32-bit sample words into a serial audio bit stream with a bit clock and a frame sync that it generates itself. Words enter through a valid/ready port into a 32-entry transmit FIFO. A serializer takes them from the FIFO one slot at a time and shifts out a chosen run of bits on `sdata`. The frame is fully programmable: the number of words per frame, the width of the first slot and of the other slots, which FIFO bit leaves first and in which direction, and the length, polarity and early/late placement of the frame sync. The block's system clock `clk` is also the master clock, and the bit clock is derived from it.

Software writes a small set of configuration words through a plain write port. A DMA engine can keep the FIFO topped up: the block raises `fifo_req` while the FIFO runs low. When a slot has to start and the FIFO is empty, the block sends zeros and sets a sticky error flag. That flag can raise an interrupt.

Back-pressure rules: a word moves into the FIFO on a rising `clk` edge when `s_valid` and `s_ready` are both high. `s_ready` is low only while the FIFO holds 32 words. A source that sees `s_ready` low holds `s_data` and `s_valid` until the transfer happens.

Top module: `audio_frame_tx`

## Requirements
- R1: With write address 1 holding DIV in bits [7:0] and the bit-clock polarity bit POL in bit 8, `bclk` has a period of (DIV+1)*2 `clk` cycles. This holds while both transmit enable (address 0 bit 0) and bit-clock enable (address 0 bit 1) are set. Otherwise `bclk` rests at the level POL. After reset all fields are zero.
- R2: `sdata` and `fsync` change only on the driving edge of `bclk`. That is the falling edge when POL=0 and the rising edge when POL=1. Both are stable across the opposite (sampling) edge.
- R3: Address 2 bits [4:0] hold words-per-frame minus one. Address 3 holds three fields:
  - bits [4:0]: slot-0 width minus one;
  - bits [12:8]: width minus one of every other slot;
  - bits [20:16]: the first-bit index F.

  Each slot carries one FIFO word, in FIFO order, starting with bit F. With MSB-first (address 2 bit 16) set, the bit index counts down from F; with it clear, the index counts up. The index wraps modulo 32.
- R4: Address 2 bits [12:8] hold S, the sync length minus one. Without early sync, the frame sync is active for the first S+1 bit clocks of each frame. Address 2 bit 18 makes the sync active low. When inactive, `fsync` equals that polarity bit.
- R5: With early sync (address 2 bit 17) set, the sync is active on the last bit of each frame and on the first S bits of the next one. The first frame after start is preceded by one lead bit clock, with the sync active and `sdata` at 0.
- R6: The first frame starts only when both enables are set and the FIFO holds at least one word. Until then `sdata` is 0 and `fsync` is inactive.
- R7: The FIFO holds 32 words and keeps their order. `s_ready` is low exactly when the FIFO is full.
- R8: `fifo_req` is high while the FIFO-request enable (address 0 bit 2) is set and the FIFO count is at or below the watermark in address 4 bits [4:0].
- R9: The error flag works as follows:
  - If a slot must start while the FIFO is empty, that slot sends zeros and the flag `err_flag` is set.
  - The flag stays set until a write to address 0 with bit 8 at 1 clears it.
  - `irq` equals `err_flag` AND the error-interrupt enable (address 0 bit 3).
- R10: Writes to addresses 1 to 4 have no effect while transmit enable is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System and master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| s_valid | input | 1 | Sample word valid |
| s_data | input | 32 | Sample word |
| s_ready | output | 1 | FIFO can accept a word |
| bclk | output | 1 | Generated bit clock |
| fsync | output | 1 | Frame sync |
| sdata | output | 1 | Serial data |
| fifo_req | output | 1 | FIFO refill request toward DMA |
| err_flag | output | 1 | Sticky underrun flag |
| irq | output | 1 | Error interrupt |

## Verification
The assertions assume three things:
- Divider and frame fields change only while transmit is disabled.
- The sync length does not exceed the frame length.
- The sample source obeys the ready handshake.

The bench follows these rules. It writes divider and frame fields only with transmit clear, except for one deliberate write that R10 expects to be ignored. It picks sync lengths shorter than the frame. It raises `s_valid` only for one cycle at a time while `s_ready` is high. It compares the serial stream with a frame model built from the configuration, sampling on the edge opposite the driving one.

// File: rtl/afx_pkg.sv
package afx_pkg;
  localparam int WORD_W = 32;
  localparam int IDX_W  = $clog2(WORD_W);
  localparam int DIV_W  = 8;

  localparam logic [2:0] ADDR_CTRL  = 3'd0;
  localparam logic [2:0] ADDR_CLK   = 3'd1;
  localparam logic [2:0] ADDR_FRAME = 3'd2;
  localparam logic [2:0] ADDR_SLOT  = 3'd3;
  localparam logic [2:0] ADDR_LEVEL = 3'd4;

  typedef struct packed {
    logic [IDX_W-1:0] words_m1;
    logic [IDX_W-1:0] sync_m1;
    logic [IDX_W-1:0] w0_m1;
    logic [IDX_W-1:0] wn_m1;
    logic [IDX_W-1:0] first_idx;
    logic             msb_first;
    logic             early;
    logic             fs_low;
  } frame_cfg_t;
endpackage

// File: rtl/afx_fifo.sv
module afx_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     head,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             wr_ok, rd_ok;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);
  assign wr_ok = push && !full;
  assign rd_ok = pop && !empty;
  assign head  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_ok) wr_ptr <= bump(wr_ptr);
      if (rd_ok) rd_ptr <= bump(rd_ptr);
      case ({wr_ok, rd_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R7
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> full);
endmodule

// File: rtl/afx_bclk_gen.sv
module afx_bclk_gen
  import afx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  input  logic             pol,
  output logic             bclk,
  output logic             drive_tick
);
  logic [DIV_W-1:0] cnt;
  logic             raw;
  logic             wrap;

  assign wrap       = (cnt == div);
  assign drive_tick = run && wrap && raw;
  assign bclk       = raw ^ pol;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt <= '0;
      raw <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      raw <= ~raw;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R1
  div_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= div));
endmodule

// File: rtl/afx_serializer.sv
module afx_serializer
  import afx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              tick,
  input  frame_cfg_t        cfg,
  input  logic              fifo_empty,
  input  logic [WORD_W-1:0] fifo_head,
  output logic              pop,
  output logic              underrun,
  output logic              sdata,
  output logic              fsync
);
  localparam int POS_W = IDX_W + 1;

  typedef enum logic [1:0] {S_IDLE, S_LEAD, S_RUN} st_t;

  st_t               st;
  logic [IDX_W-1:0]  bit_k, word_n, idx;
  logic [POS_W-1:0]  pos;
  logic [WORD_W-1:0] cur_word;
  logic              sd_q, fs_q;

  logic [IDX_W-1:0]  cur_w, sel_idx, next_idx;
  logic [WORD_W-1:0] load_word;
  logic              word_start, last_bit, frame_end;
  logic              emit, go_lead, bit_val, fs_now;

  always_comb begin
    cur_w      = (word_n == '0) ? cfg.w0_m1 : cfg.wn_m1;
    word_start = (bit_k == '0);
    last_bit   = (bit_k == cur_w);
    frame_end  = last_bit && (word_n == cfg.words_m1);
    load_word  = fifo_empty ? '0 : fifo_head;
    sel_idx    = word_start ? cfg.first_idx : idx;
    next_idx   = cfg.msb_first ? IDX_W'(sel_idx - 1'b1) : IDX_W'(sel_idx + 1'b1);
    bit_val    = word_start ? load_word[cfg.first_idx] : cur_word[idx];
    if (cfg.early) fs_now = frame_end || (pos < {1'b0, cfg.sync_m1});
    else           fs_now = (pos <= {1'b0, cfg.sync_m1});
    go_lead    = tick && (st == S_IDLE) && !fifo_empty && cfg.early;
    emit       = tick && ((st == S_RUN) || (st == S_LEAD) ||
                 ((st == S_IDLE) && !fifo_empty && !cfg.early));
  end

  assign pop      = emit && word_start && !fifo_empty;
  assign underrun = emit && word_start && fifo_empty;
  assign sdata    = sd_q;
  assign fsync    = fs_q ^ cfg.fs_low;

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      st       <= S_IDLE;
      bit_k    <= '0;
      word_n   <= '0;
      pos      <= '0;
      idx      <= '0;
      cur_word <= '0;
      sd_q     <= 1'b0;
      fs_q     <= 1'b0;
    end else if (go_lead) begin
      st   <= S_LEAD;
      sd_q <= 1'b0;
      fs_q <= 1'b1;
    end else if (emit) begin
      st   <= S_RUN;
      sd_q <= bit_val;
      fs_q <= fs_now;
      idx  <= next_idx;
      if (word_start) cur_word <= load_word;
      if (frame_end) begin
        bit_k  <= '0;
        word_n <= '0;
        pos    <= '0;
      end else begin
        if (last_bit) begin
          bit_k  <= '0;
          word_n <= word_n + 1'b1;
        end else begin
          bit_k <= bit_k + 1'b1;
        end
        if (pos != '1) pos <= pos + 1'b1;
      end
    end
  end

  // R2
  stable_off_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !tick) |=> ($stable(sd_q) && $stable(fs_q)));

  // R6
  wait_for_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_IDLE) && fifo_empty) |=> (st == S_IDLE));

  // R3
  pop_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (tick && enable));
endmodule

// File: rtl/audio_frame_tx.sv
module audio_frame_tx
  import afx_pkg::*;
#(
  parameter int FIFO_DEPTH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              s_valid,
  input  logic [WORD_W-1:0] s_data,
  output logic              s_ready,
  output logic              bclk,
  output logic              fsync,
  output logic              sdata,
  output logic              fifo_req,
  output logic              err_flag,
  output logic              irq
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  logic             tx_en_q, bclk_en_q, dma_en_q, err_ie_q, err_q;
  logic [DIV_W-1:0] div_q;
  logic             pol_q;
  logic [IDX_W-1:0] wm_q;
  frame_cfg_t       cfg_q;

  logic             cfg_open, run, tick;
  logic             pop, underrun, full, empty, clr_err;
  logic [WORD_W-1:0] head;
  logic [CNT_W-1:0] count;
  logic             cfg_unused;

  assign cfg_unused = ^{cfg_wdata[31:21], cfg_wdata[15:13]};
  assign cfg_open   = cfg_we && !tx_en_q;
  assign clr_err    = cfg_we && (cfg_addr == ADDR_CTRL) && cfg_wdata[8];
  assign run        = tx_en_q && bclk_en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_en_q   <= 1'b0;
      bclk_en_q <= 1'b0;
      dma_en_q  <= 1'b0;
      err_ie_q  <= 1'b0;
      div_q     <= '0;
      pol_q     <= 1'b0;
      wm_q      <= '0;
      cfg_q     <= '0;
    end else begin
      if (cfg_we && cfg_addr == ADDR_CTRL) begin
        tx_en_q   <= cfg_wdata[0];
        bclk_en_q <= cfg_wdata[1];
        dma_en_q  <= cfg_wdata[2];
        err_ie_q  <= cfg_wdata[3];
      end
      if (cfg_open) begin
        case (cfg_addr)
          ADDR_CLK: begin
            div_q <= cfg_wdata[DIV_W-1:0];
            pol_q <= cfg_wdata[8];
          end
          ADDR_FRAME: begin
            cfg_q.words_m1  <= cfg_wdata[4:0];
            cfg_q.sync_m1   <= cfg_wdata[12:8];
            cfg_q.msb_first <= cfg_wdata[16];
            cfg_q.early     <= cfg_wdata[17];
            cfg_q.fs_low    <= cfg_wdata[18];
          end
          ADDR_SLOT: begin
            cfg_q.w0_m1     <= cfg_wdata[4:0];
            cfg_q.wn_m1     <= cfg_wdata[12:8];
            cfg_q.first_idx <= cfg_wdata[20:16];
          end
          ADDR_LEVEL: wm_q <= cfg_wdata[4:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        err_q <= 1'b0;
    else if (underrun) err_q <= 1'b1;
    else if (clr_err)  err_q <= 1'b0;
  end

  assign err_flag = err_q;
  assign irq      = err_q && err_ie_q;
  assign s_ready  = !full;
  assign fifo_req = dma_en_q && (count <= CNT_W'(wm_q));

  afx_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(s_valid), .din(s_data), .pop(pop),
    .head(head), .count(count), .full(full), .empty(empty)
  );

  afx_bclk_gen u_bclk (
    .clk(clk), .rst_n(rst_n), .run(run), .div(div_q), .pol(pol_q),
    .bclk(bclk), .drive_tick(tick)
  );

  afx_serializer u_ser (
    .clk(clk), .rst_n(rst_n), .enable(run), .tick(tick), .cfg(cfg_q),
    .fifo_empty(empty), .fifo_head(head), .pop(pop), .underrun(underrun),
    .sdata(sdata), .fsync(fsync)
  );

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !clr_err) |=> err_q);

  // R10
  cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en_q && $past(tx_en_q)) |-> ($stable(div_q) && $stable(cfg_q)));

  // R8
  req_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_req && !s_valid) |=> (fifo_req || !dma_en_q || $past(pop) || $past(cfg_we)));
endmodule

// File: tb/audio_frame_tx_tb.sv
module audio_frame_tx_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic s_valid = 1'b0;
  logic [31:0] s_data = '0;
  logic s_ready, bclk, fsync, sdata, fifo_req, err_flag, irq;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int word_seq = 0;
  bit finished = 1'b0;
  logic cap_fs [0:255];
  logic cap_sd [0:255];
  logic exp_fs [0:255];
  logic exp_sd [0:255];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  audio_frame_tx u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .s_valid(s_valid), .s_data(s_data),
    .s_ready(s_ready), .bclk(bclk), .fsync(fsync), .sdata(sdata),
    .fifo_req(fifo_req), .err_flag(err_flag), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_tb();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  function automatic logic [31:0] pattern(input int i);
    logic [7:0] b;
    b = 8'(i * 37 + 11);
    return {b, ~b, b ^ 8'h5A, b ^ 8'hC3};
  endfunction

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic push_word(input logic [31:0] w);
    @(negedge clk);
    s_valid = 1'b1; s_data = w;
    @(posedge clk); #1;
    s_valid = 1'b0;
  endtask

  task automatic capture(input int n, input int pol);
    for (int i = 0; i < n; i++) begin
      if (pol == 0) @(posedge bclk); else @(negedge bclk);
      #1;
      cap_fs[i] = fsync;
      cap_sd[i] = sdata;
    end
  endtask

  task automatic measure_period(output int p);
    int t0;
    @(posedge bclk); #1 t0 = cyc;
    @(posedge bclk); #1 p = cyc - t0;
  endtask

  // Frame test covering R2, R3, R4, R5 (and R6 when push_late).
  task automatic run_frames(input string req, input int wm1, input int sync,
                            input int w0, input int wn, input int fbt,
                            input bit msb, input bit early, input bit fsl,
                            input int div, input int pol, input int nfr,
                            input bit push_late);
    int n, j, ncap, nw, mism;
    logic [4:0] bi;
    logic [31:0] val;
    n = 0;
    reg_write(3'd0, 32'h100);
    reg_write(3'd1, {23'd0, pol[0], div[7:0]});
    reg_write(3'd2, {13'd0, fsl, early, msb, 3'd0, sync[4:0], 3'd0, wm1[4:0]});
    reg_write(3'd3, {11'd0, fbt[4:0], 3'd0, wn[4:0], 3'd0, w0[4:0]});
    nw = nfr * (wm1 + 1);
    if (!push_late)
      for (int k = 0; k < nw; k++) push_word(pattern(word_seq + k));
    if (early) begin exp_fs[n] = 1'b1; exp_sd[n] = 1'b0; n++; end
    for (int f = 0; f < nfr; f++) begin
      int p;
      int flen;
      p = 0;
      flen = (w0 + 1) + wm1 * (wn + 1);
      for (int w = 0; w <= wm1; w++) begin
        int wid;
        wid = (w == 0) ? w0 + 1 : wn + 1;
        val = pattern(word_seq + f * (wm1 + 1) + w);
        bi = fbt[4:0];
        for (int k = 0; k < wid; k++) begin
          exp_sd[n] = val[bi];
          exp_fs[n] = early ? ((p < sync) || (p == flen - 1)) : (p <= sync);
          bi = msb ? bi - 5'd1 : bi + 5'd1;
          p++; n++;
        end
      end
    end
    reg_write(3'd0, 32'h3);
    if (push_late) begin
      repeat (40) @(negedge clk);
      chk(fsync == fsl && sdata == 1'b0, "R6", "quiet before data",
          {30'd0, fsync, sdata}, {30'd0, fsl, 1'b0});
      for (int k = 0; k < nw; k++) push_word(pattern(word_seq + k));
    end
    ncap = n + 6;
    capture(ncap, pol);
    j = -1;
    for (int i = 0; i < ncap; i++)
      if (j < 0 && cap_fs[i] != fsl) j = i;
    chk(j >= 0 && j < 6, req, "frame start found", j, 0);
    if (j >= 0 && j < 6) begin
      for (int i = 0; i < j; i++)
        chk(cap_sd[i] == 1'b0, "R6", "sdata before frame", cap_sd[i], 0);
      mism = 0;
      for (int i = 0; i < n; i++) begin
        if (mism == 0 && ((cap_fs[j+i] ^ fsl) != exp_fs[i] || cap_sd[j+i] != exp_sd[i])) begin
          mism = 1;
          chk(1'b0, req, $sformatf("bit %0d {fs,sd}", i),
              {30'd0, cap_fs[j+i] ^ fsl, cap_sd[j+i]}, {30'd0, exp_fs[i], exp_sd[i]});
        end
      end
      if (mism == 0) chk(1'b1, req, "stream", 0, 0);
    end
    reg_write(3'd0, 32'h100);
    word_seq += nw;
  endtask

  task automatic t_reset();
    chk(bclk == 1'b0, "R1", "reset bclk", bclk, 0);
    chk(fsync == 1'b0 && sdata == 1'b0, "R6", "reset fsync/sdata", {fsync, sdata}, 0);
    chk(s_ready == 1'b1, "R7", "reset s_ready", s_ready, 1);
    chk(fifo_req == 1'b0, "R8", "reset fifo_req", fifo_req, 0);
    chk(err_flag == 1'b0 && irq == 1'b0, "R9", "reset err/irq", {err_flag, irq}, 0);
  endtask

  task automatic t_divider();
    int p;
    logic seen;
    reg_write(3'd1, 32'h7);
    reg_write(3'd0, 32'h1);
    seen = 1'b0;
    repeat (60) begin @(negedge clk); if (bclk) seen = 1'b1; end
    chk(!seen, "R1", "bclk held without bclk enable", seen, 0);
    reg_write(3'd0, 32'h3);
    measure_period(p);
    chk(p == 16, "R1", "period DIV=7", p, 16);
    reg_write(3'd0, 32'h0);
    reg_write(3'd1, 32'h0);
    reg_write(3'd0, 32'h3);
    measure_period(p);
    chk(p == 2, "R1", "period DIV=0", p, 2);
    reg_write(3'd0, 32'h0);
    reg_write(3'd1, 32'h100);
    @(negedge clk);
    chk(bclk == 1'b1, "R1", "idle level with POL=1", bclk, 1);
    reg_write(3'd1, 32'h0);
  endtask

  task automatic t_lock();
    int p;
    reg_write(3'd1, 32'h3);
    reg_write(3'd0, 32'h3);
    measure_period(p);
    chk(p == 8, "R10", "period DIV=3", p, 8);
    reg_write(3'd1, 32'h0);
    measure_period(p);
    measure_period(p);
    chk(p == 8, "R10", "divider write ignored while enabled", p, 8);
    reg_write(3'd0, 32'h0);
    reg_write(3'd0, 32'h3);
    measure_period(p);
    chk(p == 8, "R10", "ignored write did not land", p, 8);
    reg_write(3'd0, 32'h0);
    reg_write(3'd1, 32'h0);
    reg_write(3'd0, 32'h3);
    measure_period(p);
    chk(p == 2, "R10", "write while disabled lands", p, 2);
    reg_write(3'd0, 32'h0);
  endtask

  task automatic t_fifo_underrun();
    int waited;
    reg_write(3'd0, 32'h100);
    reg_write(3'd4, 32'h3);
    reg_write(3'd0, 32'h4);
    @(negedge clk);
    chk(fifo_req == 1'b1, "R8", "req at count 0", fifo_req, 1);
    for (int k = 0; k < 3; k++) push_word(32'hFFFF_FFFF);
    @(negedge clk);
    chk(fifo_req == 1'b1, "R8", "req at count 3 (= watermark)", fifo_req, 1);
    push_word(32'hFFFF_FFFF);
    @(negedge clk);
    chk(fifo_req == 1'b0, "R8", "req off at count 4", fifo_req, 0);
    reg_write(3'd0, 32'h0);
    reg_write(3'd4, 32'h1F);
    @(negedge clk);
    chk(fifo_req == 1'b0, "R8", "req off without enable", fifo_req, 0);
    for (int k = 4; k < 31; k++) push_word(32'hFFFF_FFFF);
    @(negedge clk);
    chk(s_ready == 1'b1, "R7", "ready at 31 words", s_ready, 1);
    push_word(32'hFFFF_FFFF);
    @(negedge clk);
    chk(s_ready == 1'b0, "R7", "not ready when full", s_ready, 0);
    reg_write(3'd1, 32'h0);
    reg_write(3'd2, 32'h0);
    reg_write(3'd3, 32'h001F_001F);
    reg_write(3'd0, 32'hB);
    waited = 0;
    while (!err_flag && waited < 5000) begin @(negedge clk); waited++; end
    chk(err_flag == 1'b1, "R9", "underrun sets flag", err_flag, 1);
    chk(irq == 1'b1, "R9", "irq with enable", irq, 1);
    capture(40, 0);
    begin
      logic any;
      any = 1'b0;
      for (int i = 0; i < 40; i++) any |= cap_sd[i];
      chk(!any, "R9", "zeros during underrun", any, 0);
    end
    reg_write(3'd0, 32'h8);
    @(negedge clk);
    chk(err_flag == 1'b1, "R9", "flag sticky after disable", err_flag, 1);
    reg_write(3'd0, 32'h0);
    @(negedge clk);
    chk(irq == 1'b0 && err_flag == 1'b1, "R9", "irq masked", {irq, err_flag}, 1);
    reg_write(3'd0, 32'h108);
    @(negedge clk);
    chk(err_flag == 1'b0 && irq == 1'b0, "R9", "write-1 clears", {err_flag, irq}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "WD", "watchdog expired", 0, 1);
    finish_tb();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_divider();
    t_lock();
    // R3 R4 R5 R2: two 24-bit slots, early active-low sync, POL=1
    run_frames("R5", 1, 23, 23, 23, 31, 1'b1, 1'b1, 1'b1, 1, 1, 2, 1'b0);
    // R3 R4 R2: LSB first from bit 4, unequal slot widths, POL=0
    run_frames("R3", 2, 0, 7, 3, 4, 1'b0, 1'b0, 1'b0, 0, 0, 2, 1'b0);
    // R4: sync of three bits, MSB first wrapping below bit 0
    run_frames("R4", 1, 2, 5, 5, 2, 1'b1, 1'b0, 1'b0, 2, 0, 2, 1'b0);
    // R6: enable with empty FIFO, then supply data
    run_frames("R6", 0, 0, 7, 7, 7, 1'b1, 1'b0, 1'b0, 3, 0, 2, 1'b1);
    t_fifo_underrun();
    finish_tb();
  end
endmodule